// File: doc/BRIEF.md
# Periodic Transfer Segment Generator

This block turns one buffer description into a stream of transfer segments for a DMA engine's execution stage. A buffer is given by its base address, total byte length, period length and the largest segment the engine may move at once, together with a direction, per-side address increment flags, a repeat flag and an interrupt-request flag. The generator emits one segment at a time over a valid/ready handshake. Each segment carries a source address, a destination address, a byte length, an interrupt tag and an end-of-pass marker.

Segments are cut at the maximum segment length and also wherever a period of the buffer completes, so no segment ever straddles a period boundary. With interrupts requested, the segment that completes a period is tagged in repeat mode, and the final segment of every pass is always tagged. Without interrupts the whole buffer counts as a single period and nothing is tagged. In repeat mode the generator returns to the first segment after the last one is accepted. It keeps doing so until the stop input is raised. Bad configurations are refused with an error pulse.

Top module: `period_seg_gen`

## Requirements
- R1: One cycle after `start` is sampled high while idle with a valid configuration, `seg_valid` is high and the first segment is presented. With `cfg_to_mem`=0 its source is `cfg_buf_addr` and its destination is `cfg_dev_addr`. With `cfg_to_mem`=1 the two are swapped.
- R2: Every segment length is nonzero and equals the smallest of three values: the bytes remaining in the pass, `cfg_max_seg`, and the bytes still missing from the current period.
- R3: A segment whose length would reach or pass the end of the current period is shortened so that it ends exactly on that boundary. The period byte count then starts again from zero.
- R4: `seg_irq` is high only when `cfg_irq_en` was set. In that case it is high on the final segment of every pass, and also on any period-completing segment when `cfg_cyclic` was set.
- R5: With `cfg_irq_en`=0, `cfg_period_len` is ignored and the period equals the buffer length. Segments are then cut only by `cfg_max_seg` and the end of the buffer.
- R6: After a segment is accepted, the source address advances by that segment's length if `cfg_src_inc` was set and the current source address is nonzero. Otherwise it is unchanged. The destination address follows the same rule with `cfg_dst_inc`.
- R7: `seg_last` is high exactly on the final segment of a pass. In non-repeat mode, accepting that segment makes `busy` and `seg_valid` low in the next cycle.
- R8: In repeat mode, accepting the final segment makes the next segment the first segment of the buffer again, with its original addresses and lengths.
- R9: A `start` with zero buffer length, zero maximum segment length, or zero period length while `cfg_irq_en`=1 emits no segment. Instead `cfg_err` is high for exactly the one following cycle and `busy` stays low.
- R10: `stop` high at a clock edge makes `seg_valid` and `busy` low from the next cycle, whether or not the segment was ready.
- R11: While `seg_valid` is high and `seg_ready` is low, the presented segment holds all of its fields unchanged.
- R12: `sum_err` pulses after a final segment if the lengths emitted in that pass do not add up to the buffer length. For every accepted configuration it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin generation with the cfg_* values (sampled when idle) |
| cfg_buf_addr | input | AW | Memory buffer base address |
| cfg_dev_addr | input | AW | Fixed device-side address |
| cfg_buf_len | input | LW | Total buffer length in bytes |
| cfg_period_len | input | LW | Period length in bytes |
| cfg_max_seg | input | LW | Largest allowed segment length |
| cfg_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| cfg_src_inc | input | 1 | Advance source address per segment |
| cfg_dst_inc | input | 1 | Advance destination address per segment |
| cfg_cyclic | input | 1 | Repeat the buffer until stopped |
| cfg_irq_en | input | 1 | Interrupt tagging requested |
| stop | input | 1 | Abort and return to idle |
| seg_valid | output | 1 | Segment presented |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_src | output | AW | Segment source address |
| seg_dst | output | AW | Segment destination address |
| seg_len | output | LW | Segment length in bytes |
| seg_irq | output | 1 | Interrupt tag |
| seg_last | output | 1 | Final segment of the pass |
| busy | output | 1 | Generation in progress |
| cfg_err | output | 1 | One-cycle pulse on a refused configuration |
| sum_err | output | 1 | One-cycle pulse on a length sum mismatch |

## Verification
The assertions watch the per-cycle invariants on every cycle. These are: the length bounds against the maximum, the remaining count and the period room; segment stability under backpressure; the return to idle after stop; the idle state during a configuration error; interrupt tags only when requested; address stepping; and the reload on a repeat pass. Only the bench's scenarios can show that the whole ordered segment sequence is right. That covers the exact cut points in configurations where the period is not a multiple of the maximum length, and buffers that are not a multiple of the period. It also covers the interrupt pattern across passes, the direction swap of the addresses, and the zero-address rule for increments. The bench checks these against a reference sequence it builds from the requirements, using random backpressure.

// File: rtl/psg_pkg.sv
package psg_pkg;
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_t;
endpackage

// File: rtl/psg_cut.sv
module psg_cut #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] rem,
  input  logic [LW-1:0] pcnt,
  input  logic [LW-1:0] period,
  input  logic [LW-1:0] maxlen,
  output logic [LW-1:0] seg_len,
  output logic          closes,
  output logic          is_last
);
  logic [LW-1:0] cand;
  logic [LW-1:0] room;

  always_comb begin
    cand    = (rem < maxlen) ? rem : maxlen;
    room    = period - pcnt;
    closes  = (cand >= room);
    seg_len = closes ? room : cand;
    is_last = (seg_len == rem);
  end
endmodule

// File: rtl/psg_addr.sv
module psg_addr #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cfg,
  input  logic          rewind,
  input  logic          step,
  input  logic [AW-1:0] base_in,
  input  logic          inc_in,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          inc_q, inc_d;
  logic          base_en, addr_en;

  always_comb begin
    base_en = load_cfg;
    base_d  = base_in;
    inc_d   = inc_in;
    addr_en = load_cfg | rewind | step;
    if (load_cfg)
      addr_d = base_in;
    else if (rewind)
      addr_d = base_q;
    else if (inc_q && (addr_q != '0))
      addr_d = addr_q + AW'(len);
    else
      addr_d = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      inc_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      if (base_en) begin
        base_q <= base_d;
        inc_q  <= inc_d;
      end
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_cfg && !rewind && inc_q && addr_q != '0)
      |=> (addr_q == $past(addr_q) + AW'($past(len))));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_cfg && !rewind && (!inc_q || addr_q == '0))
      |=> $stable(addr_q));
endmodule

// File: rtl/period_seg_gen.sv
module period_seg_gen
  import psg_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_buf_addr,
  input  logic [AW-1:0] cfg_dev_addr,
  input  logic [LW-1:0] cfg_buf_len,
  input  logic [LW-1:0] cfg_period_len,
  input  logic [LW-1:0] cfg_max_seg,
  input  logic          cfg_to_mem,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic          cfg_cyclic,
  input  logic          cfg_irq_en,
  input  logic          stop,
  output logic          seg_valid,
  input  logic          seg_ready,
  output logic [AW-1:0] seg_src,
  output logic [AW-1:0] seg_dst,
  output logic [LW-1:0] seg_len,
  output logic          seg_irq,
  output logic          seg_last,
  output logic          busy,
  output logic          cfg_err,
  output logic          sum_err
);
  localparam int NSIDE = 2;
  localparam int CW    = LW + 1;

  gen_state_t    state_q, state_d;
  logic [LW-1:0] len_q, period_q, max_q;
  logic [LW-1:0] len_d, period_d, max_d;
  logic          cyc_q, irq_q, cyc_d, irq_d;
  logic [LW-1:0] rem_q, rem_d, pcnt_q, pcnt_d;
  logic [CW-1:0] acc_q, acc_d;
  logic          cfg_err_q, cfg_err_d, sum_err_q, sum_err_d;
  logic          cfg_en, cnt_en;

  logic          is_idle, cfg_bad, take_cfg, xfer, wrap;
  logic [LW-1:0] cut_len;
  logic          cut_close, cut_last;
  logic [LW-1:0] period_eff;
  logic [CW-1:0] acc_sum;

  logic [AW-1:0] side_base [NSIDE];
  logic          side_inc  [NSIDE];
  logic [AW-1:0] side_addr [NSIDE];

  // Start qualification
  always_comb begin
    is_idle    = (state_q == GEN_IDLE);
    cfg_bad    = (cfg_buf_len == '0) || (cfg_max_seg == '0) ||
                 (cfg_irq_en && (cfg_period_len == '0));
    take_cfg   = is_idle && start && !cfg_bad;
    period_eff = cfg_irq_en ? cfg_period_len : cfg_buf_len;
    xfer       = (state_q == GEN_RUN) && seg_ready && !stop;
    wrap       = xfer && cut_last && cyc_q;
  end

  psg_cut #(.LW(LW)) u_cut (
    .rem     (rem_q),
    .pcnt    (pcnt_q),
    .period  (period_q),
    .maxlen  (max_q),
    .seg_len (cut_len),
    .closes  (cut_close),
    .is_last (cut_last)
  );

  // Address sides: index 0 is source, index 1 is destination
  always_comb begin
    side_base[0] = cfg_to_mem ? cfg_dev_addr : cfg_buf_addr;
    side_base[1] = cfg_to_mem ? cfg_buf_addr : cfg_dev_addr;
    side_inc[0]  = cfg_src_inc;
    side_inc[1]  = cfg_dst_inc;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    psg_addr #(.AW(AW), .LW(LW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_cfg (take_cfg),
      .rewind   (wrap),
      .step     (xfer && !cut_last),
      .base_in  (side_base[g]),
      .inc_in   (side_inc[g]),
      .len      (cut_len),
      .addr     (side_addr[g])
    );
  end

  // Next state
  always_comb begin
    state_d   = state_q;
    cfg_en    = take_cfg;
    len_d     = cfg_buf_len;
    period_d  = period_eff;
    max_d     = cfg_max_seg;
    cyc_d     = cfg_cyclic;
    irq_d     = cfg_irq_en;
    cnt_en    = 1'b0;
    rem_d     = rem_q;
    pcnt_d    = pcnt_q;
    acc_d     = acc_q;
    acc_sum   = acc_q + CW'(cut_len);
    cfg_err_d = is_idle && start && cfg_bad;
    sum_err_d = 1'b0;

    unique case (state_q)
      GEN_IDLE: begin
        if (take_cfg) begin
          state_d = GEN_RUN;
          cnt_en  = 1'b1;
          rem_d   = cfg_buf_len;
          pcnt_d  = '0;
          acc_d   = '0;
        end
      end
      GEN_RUN: begin
        if (stop) begin
          state_d = GEN_IDLE;
        end else if (xfer) begin
          cnt_en = 1'b1;
          if (cut_last) begin
            sum_err_d = (acc_sum != CW'(len_q));
            rem_d     = len_q;
            pcnt_d    = '0;
            acc_d     = '0;
            if (!cyc_q) state_d = GEN_IDLE;
          end else begin
            rem_d  = rem_q - cut_len;
            pcnt_d = cut_close ? '0 : (pcnt_q + cut_len);
            acc_d  = acc_sum;
          end
        end
      end
      default: state_d = GEN_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= GEN_IDLE;
      len_q     <= '0;
      period_q  <= '0;
      max_q     <= '0;
      cyc_q     <= 1'b0;
      irq_q     <= 1'b0;
      rem_q     <= '0;
      pcnt_q    <= '0;
      acc_q     <= '0;
      cfg_err_q <= 1'b0;
      sum_err_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cfg_err_q <= cfg_err_d;
      sum_err_q <= sum_err_d;
      if (cfg_en) begin
        len_q    <= len_d;
        period_q <= period_d;
        max_q    <= max_d;
        cyc_q    <= cyc_d;
        irq_q    <= irq_d;
      end
      if (cnt_en) begin
        rem_q  <= rem_d;
        pcnt_q <= pcnt_d;
        acc_q  <= acc_d;
      end
    end
  end

  // Outputs
  always_comb begin
    seg_valid = (state_q == GEN_RUN);
    busy      = (state_q == GEN_RUN);
    seg_src   = side_addr[0];
    seg_dst   = side_addr[1];
    seg_len   = cut_len;
    seg_last  = seg_valid && cut_last;
    seg_irq   = seg_valid && irq_q && (cut_last || (cut_close && cyc_q));
    cfg_err   = cfg_err_q;
    sum_err   = sum_err_q;
  end

  // Checks next to the logic
  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0) && (seg_len <= max_q) && (seg_len <= rem_q));

  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (CW'(pcnt_q) + CW'(seg_len) <= CW'(period_q)));

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_irq |-> irq_q);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && !stop && seg_last && !cyc_q) |=> !busy);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && !stop && seg_last && cyc_q)
      |=> (seg_valid && rem_q == len_q && pcnt_q == '0));

  p_cfg_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!busy && !seg_valid));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!seg_valid && !busy));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready && !stop)
      |=> (seg_valid && $stable(seg_src) && $stable(seg_dst) && $stable(seg_len)));
endmodule

// File: tb/period_seg_gen_test.sv
`timescale 1ns/1ps
module period_seg_gen_test;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk, rst_n, start, stop, seg_ready;
  logic [AW-1:0] cfg_buf_addr, cfg_dev_addr;
  logic [LW-1:0] cfg_buf_len, cfg_period_len, cfg_max_seg;
  logic          cfg_to_mem, cfg_src_inc, cfg_dst_inc, cfg_cyclic, cfg_irq_en;
  logic          seg_valid, seg_irq, seg_last, busy, cfg_err, sum_err;
  logic [AW-1:0] seg_src, seg_dst;
  logic [LW-1:0] seg_len;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  period_seg_gen #(.AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_buf_addr(cfg_buf_addr), .cfg_dev_addr(cfg_dev_addr),
    .cfg_buf_len(cfg_buf_len), .cfg_period_len(cfg_period_len),
    .cfg_max_seg(cfg_max_seg), .cfg_to_mem(cfg_to_mem),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_cyclic(cfg_cyclic), .cfg_irq_en(cfg_irq_en), .stop(stop),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_src(seg_src),
    .seg_dst(seg_dst), .seg_len(seg_len), .seg_irq(seg_irq),
    .seg_last(seg_last), .busy(busy), .cfg_err(cfg_err), .sum_err(sum_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual=%0d cycles expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model state
  longint m_rem, m_pcnt, m_src, m_dst, m_per;

  task automatic run_case(input int b, input int p, input int m, input bit to_mem,
                          input bit si, input bit di, input bit cyc, input bit ie,
                          input longint buf_a, input longint dev_a);
    int passes = 0;
    int guard  = 0;
    longint cand, room, elen, src0, dst0;
    bit close, elast, eirq, rdy;
    @(negedge clk);
    cfg_buf_len = LW'(b); cfg_period_len = LW'(p); cfg_max_seg = LW'(m);
    cfg_to_mem = to_mem; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_cyclic = cyc; cfg_irq_en = ie;
    cfg_buf_addr = AW'(buf_a); cfg_dev_addr = AW'(dev_a);
    start = 1'b1;
    src0 = to_mem ? dev_a : buf_a;
    dst0 = to_mem ? buf_a : dev_a;
    m_per = ie ? p : b;            // R5: period is whole buffer without irq
    m_rem = b; m_pcnt = 0; m_src = src0; m_dst = dst0;
    @(negedge clk);
    start = 1'b0;
    chk(seg_valid == 1'b1, "R1 valid after start", seg_valid, 1);
    while (guard < 20000) begin
      guard++;
      cand  = (m_rem < m) ? m_rem : m;
      room  = m_per - m_pcnt;
      close = (cand >= room);
      elen  = close ? room : cand;
      elast = (elen == m_rem);
      eirq  = ie && (elast || (close && cyc));
      chk(seg_len == LW'(elen), "R2/R3/R5 seg_len", seg_len, elen);
      chk(seg_src == AW'(m_src), "R1/R6 seg_src", seg_src, m_src);
      chk(seg_dst == AW'(m_dst), "R1/R6 seg_dst", seg_dst, m_dst);
      chk(seg_irq == eirq, "R4 seg_irq", seg_irq, eirq);
      chk(seg_last == elast, "R7 seg_last", seg_last, elast);
      rdy = ($urandom % 4) != 0;
      seg_ready = rdy;
      @(negedge clk);
      seg_ready = 1'b0;
      if (!rdy) begin
        chk(seg_valid == 1'b1, "R11 held under backpressure", seg_valid, 1);
        continue;
      end
      if (elast) begin
        passes++;
        chk(sum_err == 1'b0, "R12 sum_err", sum_err, 0);
        if (!cyc) begin
          chk(busy == 1'b0 && seg_valid == 1'b0, "R7 idle after last", busy, 0);
          break;
        end
        m_rem = b; m_pcnt = 0; m_src = src0; m_dst = dst0;   // R8
        chk(seg_src == AW'(src0), "R8 rewind src", seg_src, src0);
        if (passes >= 2) begin
          stop = 1'b1;
          @(negedge clk);
          stop = 1'b0;
          chk(seg_valid == 1'b0 && busy == 1'b0, "R10 stop to idle", seg_valid, 0);
          break;
        end
      end else begin
        m_rem  = m_rem - elen;
        m_pcnt = close ? 0 : m_pcnt + elen;
        if (si && m_src != 0) m_src = (m_src + elen) & 64'hFFFF_FFFF;
        if (di && m_dst != 0) m_dst = (m_dst + elen) & 64'hFFFF_FFFF;
      end
    end
  endtask

  task automatic bad_cfg(input int b, input int p, input int m, input bit ie);
    @(negedge clk);
    cfg_buf_len = LW'(b); cfg_period_len = LW'(p); cfg_max_seg = LW'(m);
    cfg_irq_en = ie; cfg_cyclic = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1'b1, "R9 cfg_err pulse", cfg_err, 1);
    chk(seg_valid == 1'b0 && busy == 1'b0, "R9 no segment", seg_valid, 0);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R9 single pulse", cfg_err, 0);
    chk(busy == 1'b0, "R9 stays idle", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; seg_ready = 1'b0;
    cfg_buf_addr = '0; cfg_dev_addr = '0; cfg_buf_len = '0;
    cfg_period_len = '0; cfg_max_seg = '0; cfg_to_mem = 1'b0;
    cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0; cfg_cyclic = 1'b0; cfg_irq_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_valid == 1'b0 && busy == 1'b0, "reset idle", seg_valid, 0);
    chk(cfg_err == 1'b0 && sum_err == 1'b0, "reset flags", cfg_err, 0);

    // Directed corners
    run_case(25, 10, 4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1000, 32'h8000); // R3/R4 cyclic
    run_case(25, 10, 4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h2000, 32'h9000); // R4 one-shot
    run_case(10, 3, 4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h3000, 32'h0);     // R5, R6 zero dst
    run_case(12, 4, 4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0, 32'h40);       // R6 zero src
    run_case(1, 1, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h10, 32'h20);
    run_case(30, 50, 7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h500, 32'h600);  // period > buffer
    bad_cfg(0, 4, 4, 1'b1);
    bad_cfg(8, 4, 0, 1'b1);
    bad_cfg(8, 0, 4, 1'b1);

    // Stop in the first cycle of a run (R10)
    @(negedge clk);
    cfg_buf_len = 16'd40; cfg_period_len = 16'd8; cfg_max_seg = 16'd5;
    cfg_irq_en = 1'b1; cfg_cyclic = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(seg_valid == 1'b0 && busy == 1'b0, "R10 early stop", busy, 0);

    // Random configurations
    for (int i = 0; i < 40; i++) begin
      int b, p, m;
      longint ba, da;
      b  = 1 + ($urandom % 200);
      p  = 1 + ($urandom % (b + 20));
      m  = 1 + ($urandom % 40);
      ba = (($urandom % 8) == 0) ? 0 : longint'($urandom);
      da = (($urandom % 8) == 0) ? 0 : longint'($urandom);
      run_case(b, p, m, $urandom % 2, $urandom % 2, $urandom % 2,
               $urandom % 2, $urandom % 2, ba, da);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule